// File: doc/BRIEF.md
# PWM Bit Codec with Bit-Wise Arbitration

This block sits between a byte-oriented serial controller and a single-wire, open-drain bus on which every bit carries its own clock. Each bit begins with a falling edge of the bus. A logic 1 is a short low pulse and a logic 0 is a long low pulse. A node in clock-master mode makes those falling edges from an incoming baud clock. A node in follower mode starts its bit timing from the falling edges it sees on the bus, and shows the recovered timing on a clock output.

Transmit data arrives as a UART-framed level stream on `txd_in`. The level present at a bit's start decides how long the node holds the bus low. The receiver reads the bus halfway between the two low widths and sends the result to `rxd_out` as a UART-framed level stream. All timing is counted in cycles of an oversampling clock `clk`, and the two low widths are parameters.

While the node is sending its own frame, each bit read back from the bus is compared with the bit that was sent. The first mismatch drops the node out: it sends only recessive bits until the bus has shown a set number of consecutive logic-1 bits.

Top module: `pwm_bit_codec`

## Requirements
- R1: While and right after `rst`, `bus_drive_low` is 0, `rxd_out` is 1, `clk_out` is 1 and `arb_lost` is 0.
- R2: With `is_master`=1, a rising edge of `baud_in` seen at a clock edge starts a bit, and `bus_drive_low` is 1 from the next cycle. For a logic 1 (`txd_in`=1 at that edge) it is held for exactly T1_LOW cycles.
- R3: In either mode, a bit whose `txd_in` level at its start is 0 holds `bus_drive_low` for exactly T0_LOW cycles counted from the bit start.
- R4: With `is_master`=0, a falling edge of `bus_in` starts a bit. `clk_out` is then 0 for exactly (T1_LOW+T0_LOW)/2 cycles, and a logic-1 bit does not drive the bus. With `is_master`=1, `clk_out` stays 1.
- R5: The bus level (1 = high) is sampled (T1_LOW+T0_LOW)/2 cycles after the bit start. `rxd_out` takes that value at that clock edge and holds it until the next sample.
- R6: A frame the node sends starts with a bit sent as 0 and spans 10 bits (start, 8 data LSB first, stop). If the sampled level in such a bit differs from the bit sent, `arb_lost` rises at that sample.
- R7: While `arb_lost` is 1, the node sends only logic 1 whatever `txd_in` is. In follower mode it does not drive at all; in clock-master mode it drives only the T1_LOW clock pulse.
- R8: `arb_lost` falls at the sample of the IFS_BITS-th consecutive logic-1 bit received, counting bits before the loss that are still part of the run.
- R9: Bits received while the node is not sending a frame (`txd_in` held 1) never set `arb_lost`, even when another node sends zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1 = clock-master mode, 0 = follower mode |
| baud_in | input | 1 | Baud clock; a rising edge starts a bit in clock-master mode |
| txd_in | input | 1 | UART-framed transmit level stream |
| bus_in | input | 1 | Bus level read back (1 = high/recessive) |
| rxd_out | output | 1 | UART-framed receive level stream |
| clk_out | output | 1 | Recovered bit clock in follower mode, low up to the decision point |
| bus_drive_low | output | 1 | 1 = pull the bus low |
| arb_lost | output | 1 | Arbitration lost, held until the recessive run clears it |

## Verification
Both modes are run through the same set of frames. First a frame is sent alone, which checks the two pulse widths and the read-back timing. Then colliding frames are sent where this node's first differing bit is a 1, which must lose, and where it is a 0, which must win. A frame that only another node sends checks that receiving alone never raises the loss flag. A sweep of byte pairs, each followed by a run of idle bits, puts the loss at many different bit positions and checks that the flag clears on exactly the recessive bit that completes the run. Idle bits in the run count toward the release.

// File: rtl/pwm_codec_pkg.sv
package pwm_codec_pkg;

    typedef enum logic {
        MODE_FOLLOW = 1'b0,
        MODE_CLOCK  = 1'b1
    } node_mode_e;

    typedef struct packed {
        logic start;   // bit begins this edge
        logic sample;  // decision point reached this edge
    } bit_evt_t;

    localparam int FRAME_LEN = 10;

    function automatic int mid_point(input int short_w, input int long_w);
        return (short_w + long_w) / 2;
    endfunction

    function automatic int cnt_width(input int long_w);
        return $clog2(long_w + 2);
    endfunction

endpackage

// File: rtl/pwm_bit_timer.sv
module pwm_bit_timer import pwm_codec_pkg::*; #(
    parameter  int T1_LOW = 4,
    parameter  int T0_LOW = 12,
    localparam int CW     = cnt_width(T0_LOW)
) (
    input  logic          clk,
    input  logic          rst,
    input  node_mode_e    mode,
    input  logic          baud_in,
    input  logic          bus_in,
    output logic [CW-1:0] cnt,
    output bit_evt_t      evt,
    output logic          clk_out
);
    localparam logic [CW-1:0] SMP_C  = CW'(mid_point(T1_LOW, T0_LOW));
    localparam logic [CW-1:0] CMAX_C = CW'(T0_LOW + 1);

    logic baud_q;
    logic bus_q;
    logic start;

    always_comb begin
        if (mode == MODE_CLOCK) start = baud_in & ~baud_q;
        else                    start = bus_q & ~bus_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            baud_q <= 1'b1;
            bus_q  <= 1'b0;
            cnt    <= '0;
        end else begin
            baud_q <= baud_in;
            bus_q  <= bus_in;
            if (start)                        cnt <= CW'(1);
            else if (cnt != '0 && cnt != CMAX_C) cnt <= cnt + CW'(1);
        end
    end

    always_comb begin
        evt.start  = start;
        evt.sample = (cnt == SMP_C);
        clk_out    = (mode == MODE_CLOCK) | ~((cnt != '0) && (cnt <= SMP_C));
    end

    // R4: the recovered clock low phase lasts more than one cycle
    a_r4_clk_low_min: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FOLLOW && $fell(clk_out)) |=> !clk_out);

endmodule

// File: rtl/pwm_tx_shaper.sv
module pwm_tx_shaper import pwm_codec_pkg::*; #(
    parameter  int T1_LOW = 4,
    parameter  int T0_LOW = 12,
    localparam int CW     = cnt_width(T0_LOW)
) (
    input  logic          clk,
    input  logic          rst,
    input  node_mode_e    mode,
    input  bit_evt_t      evt,
    input  logic [CW-1:0] cnt,
    input  logic          txd_in,
    input  logic          lost,
    output logic          tx_bit,
    output logic          drive_low
);
    localparam logic [CW-1:0] T1_C = CW'(T1_LOW);
    localparam logic [CW-1:0] T0_C = CW'(T0_LOW);

    logic clock_pulse;
    logic zero_pulse;

    always_ff @(posedge clk) begin
        if (rst)            tx_bit <= 1'b1;
        else if (evt.start) tx_bit <= txd_in | lost;
    end

    always_comb begin
        clock_pulse = (mode == MODE_CLOCK) && (cnt != '0) && (cnt <= T1_C);
        zero_pulse  = !tx_bit && !lost && (cnt != '0) && (cnt <= T0_C);
        drive_low   = clock_pulse | zero_pulse;
    end

    // R2: a clock-master bit start pulls the bus low on the next cycle
    a_r2_master_pulse: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CLOCK && evt.start) |=> drive_low);

    // R7: after a loss a follower stays off the bus
    a_r7_lost_quiet: assert property (@(posedge clk) disable iff (rst)
        (lost && $past(lost) && mode == MODE_FOLLOW) |-> !drive_low);

endmodule

// File: rtl/pwm_rx_sampler.sv
module pwm_rx_sampler import pwm_codec_pkg::*; (
    input  logic     clk,
    input  logic     rst,
    input  bit_evt_t evt,
    input  logic     bus_in,
    output logic     rxd_out
);
    always_ff @(posedge clk) begin
        if (rst)             rxd_out <= 1'b1;
        else if (evt.sample) rxd_out <= bus_in;
    end

    // R5: the receive stream moves only at the decision point
    a_r5_rxd_at_sample: assert property (@(posedge clk) disable iff (rst)
        !$stable(rxd_out) |-> $past(evt.sample));

endmodule

// File: rtl/pwm_arbiter.sv
module pwm_arbiter import pwm_codec_pkg::*; #(
    parameter  int IFS_BITS = 10,
    localparam int OW       = $clog2(IFS_BITS + 1),
    localparam int FW       = $clog2(FRAME_LEN)
) (
    input  logic     clk,
    input  logic     rst,
    input  bit_evt_t evt,
    input  logic     bus_in,
    input  logic     tx_bit,
    output logic     lost
);
    localparam logic [OW-1:0] IFS_C   = OW'(IFS_BITS);
    localparam logic [OW-1:0] IFS_M1  = OW'(IFS_BITS - 1);
    localparam logic [FW-1:0] LAST_C  = FW'(FRAME_LEN - 1);

    logic [FW-1:0] frm_pos;
    logic [OW-1:0] ones;
    logic          in_frame;
    logic          mismatch;

    always_comb begin
        in_frame = (frm_pos != '0) || !tx_bit;
        mismatch = in_frame && (bus_in != tx_bit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lost    <= 1'b0;
            frm_pos <= '0;
            ones    <= '0;
        end else if (evt.sample) begin
            if (!bus_in)           ones <= '0;
            else if (ones != IFS_C) ones <= ones + OW'(1);
            if (!lost) begin
                if (mismatch) begin
                    lost    <= 1'b1;
                    frm_pos <= '0;
                end else if (in_frame) begin
                    frm_pos <= (frm_pos == LAST_C) ? '0 : frm_pos + FW'(1);
                end
            end else if (bus_in && ones == IFS_M1) begin
                lost <= 1'b0;
            end
        end
    end

    // R6: a loss is declared only at a decision point
    a_r6_lost_at_sample: assert property (@(posedge clk) disable iff (rst)
        $rose(lost) |-> $past(evt.sample));

    // R8: release happens on a sampled recessive bit
    a_r8_release_on_one: assert property (@(posedge clk) disable iff (rst)
        $fell(lost) |-> ($past(evt.sample) && $past(bus_in)));

endmodule

// File: rtl/pwm_bit_codec.sv
module pwm_bit_codec import pwm_codec_pkg::*; #(
    parameter int T1_LOW   = 4,
    parameter int T0_LOW   = 12,
    parameter int IFS_BITS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic is_master,
    input  logic baud_in,
    input  logic txd_in,
    input  logic bus_in,
    output logic rxd_out,
    output logic clk_out,
    output logic bus_drive_low,
    output logic arb_lost
);
    localparam int CW = cnt_width(T0_LOW);

    node_mode_e    mode;
    bit_evt_t      evt;
    logic [CW-1:0] cnt;
    logic          tx_bit;

    assign mode = node_mode_e'(is_master);

    pwm_bit_timer #(.T1_LOW(T1_LOW), .T0_LOW(T0_LOW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .baud_in (baud_in),
        .bus_in  (bus_in),
        .cnt     (cnt),
        .evt     (evt),
        .clk_out (clk_out)
    );

    pwm_tx_shaper #(.T1_LOW(T1_LOW), .T0_LOW(T0_LOW)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .evt       (evt),
        .cnt       (cnt),
        .txd_in    (txd_in),
        .lost      (arb_lost),
        .tx_bit    (tx_bit),
        .drive_low (bus_drive_low)
    );

    pwm_rx_sampler u_rx (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .bus_in  (bus_in),
        .rxd_out (rxd_out)
    );

    pwm_arbiter #(.IFS_BITS(IFS_BITS)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .bus_in (bus_in),
        .tx_bit (tx_bit),
        .lost   (arb_lost)
    );

endmodule

// File: tb/pwm_bit_codec_bench.sv
`timescale 1ns/1ps
module pwm_bit_codec_bench;
    localparam int T1  = 4;
    localparam int T0  = 12;
    localparam int IFS = 10;
    localparam int SMP = (T1 + T0) / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic is_master = 1'b1;
    logic baud_in = 1'b0;
    logic txd_in = 1'b1;
    logic ext_low = 1'b0;
    logic bus_w;
    logic rxd_out, clk_out, bus_drive_low, arb_lost;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    bit m_lost;
    int m_frm;
    int m_ones;
    bit prev_rx;

    always #2 clk = ~clk;

    assign bus_w = ~(bus_drive_low | ext_low);

    pwm_bit_codec #(.T1_LOW(T1), .T0_LOW(T0), .IFS_BITS(IFS)) u_pwm_bit_codec (
        .clk           (clk),
        .rst           (rst),
        .is_master     (is_master),
        .baud_in       (baud_in),
        .txd_in        (txd_in),
        .bus_in        (bus_w),
        .rxd_out       (rxd_out),
        .clk_out       (clk_out),
        .bus_drive_low (bus_drive_low),
        .arb_lost      (arb_lost)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset(input bit master);
        @(negedge clk);
        rst = 1'b1; is_master = master; baud_in = 1'b0; txd_in = 1'b1; ext_low = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_lost = 1'b0; m_frm = 0; m_ones = 0; prev_rx = 1'b1;
        @(negedge clk);
        chk(bus_drive_low == 1'b0, "R1", "drive after reset", int'(bus_drive_low), 0);
        chk(rxd_out == 1'b1, "R1", "rxd after reset", int'(rxd_out), 1);
        chk(clk_out == 1'b1, "R1", "clk_out after reset", int'(clk_out), 1);
        chk(arb_lost == 1'b0, "R1", "arb_lost after reset", int'(arb_lost), 0);
    endtask

    // one bit: tx = level on txd_in, oth0 = another node sends a zero
    task automatic do_bit(input bit tx, input bit oth0, input string atag);
        bit e_tx, bus_v, in_frame, was_lost;
        int exp_low, exp_clk, ext_len, lowc, clkc;
        string wtag;
        e_tx    = tx | m_lost;
        bus_v   = e_tx & ~oth0;
        exp_low = !e_tx ? T0 : (is_master ? T1 : 0);
        exp_clk = is_master ? 0 : SMP;
        ext_len = oth0 ? T0 : (is_master ? 0 : T1);
        if (!e_tx)                 wtag = "R3";
        else if (!tx && m_lost)    wtag = "R7";
        else if (is_master)        wtag = "R2";
        else                       wtag = "R4";
        lowc = 0; clkc = 0;
        @(negedge clk);
        txd_in = tx;
        if (is_master) baud_in = 1'b1;
        if (ext_len > 0) ext_low = 1'b1;
        for (int i = 1; i < 20; i++) begin
            @(negedge clk);
            if (i == ext_len) ext_low = 1'b0;
            if (i == 10) baud_in = 1'b0;
            if (bus_drive_low) lowc++;
            if (!clk_out) clkc++;
            if (i == SMP)
                chk(rxd_out == prev_rx, "R5", "rxd before sample", int'(rxd_out), int'(prev_rx));
            if (i == SMP + 1)
                chk(rxd_out == bus_v, "R5", "rxd after sample", int'(rxd_out), int'(bus_v));
        end
        chk(lowc == exp_low, wtag, "low width", lowc, exp_low);
        chk(clkc == exp_clk, "R4", "clk_out low width", clkc, exp_clk);
        // arbitration model from R6, R8, R9
        in_frame = (m_frm != 0) || !e_tx;
        was_lost = m_lost;
        if (!was_lost) begin
            if (in_frame && bus_v != e_tx) begin
                m_lost = 1'b1; m_frm = 0;
            end else if (in_frame) begin
                m_frm = (m_frm == 9) ? 0 : m_frm + 1;
            end
        end else if (bus_v && m_ones == IFS - 1) begin
            m_lost = 1'b0;
        end
        if (!bus_v) m_ones = 0;
        else if (m_ones != IFS) m_ones++;
        prev_rx = bus_v;
        chk(arb_lost == m_lost, atag, "arb_lost", int'(arb_lost), int'(m_lost));
    endtask

    task automatic send_frame(input bit txv, input logic [7:0] tb,
                              input bit ov, input logic [7:0] ob, input string atag);
        for (int j = 0; j < 10; j++) begin
            bit tbit, obit;
            tbit = (j == 0) ? 1'b0 : (j == 9) ? 1'b1 : tb[j-1];
            obit = (j == 0) ? 1'b0 : (j == 9) ? 1'b1 : ob[j-1];
            do_bit(txv ? tbit : 1'b1, ov && !obit, atag);
        end
    endtask

    task automatic idle_bits(input int n, input string atag);
        for (int j = 0; j < n; j++) do_bit(1'b1, 1'b0, atag);
    endtask

    task automatic run_suite(input bit master);
        do_reset(master);
        idle_bits(2, "R8");
        send_frame(1'b1, 8'h55, 1'b0, 8'h00, "R6");   // alone
        send_frame(1'b1, 8'hA3, 1'b1, 8'hA1, "R6");   // loses at data bit 1
        idle_bits(10, "R8");
        send_frame(1'b1, 8'hA1, 1'b1, 8'hA3, "R6");   // wins
        send_frame(1'b0, 8'h00, 1'b1, 8'h3C, "R9");   // receive only
        idle_bits(2, "R9");
        for (int k = 0; k < 8; k++) begin
            send_frame(1'b1, 8'(k * 37 + 5), 1'b1, 8'(k * 53 + 9), "R6");
            idle_bits(11, "R8");
        end
    endtask

    initial begin
        run_suite(1'b1);
        run_suite(1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule